// File: doc/BRIEF.md
# Address Translation and Access Permission Unit

This unit turns one 32-bit logical address into a physical address per request. It also checks that the access is allowed. A request carries the logical address, the access attributes (write, supervisor, instruction fetch) and the current translation-control and window register values. These values are captured when the request is accepted.

When translation is off, or the upper address byte falls inside an enabled transparent window, the result comes back in the next cycle. In that case the address passes through unchanged and no page descriptor is fetched. Otherwise the unit asks an external walker or TLB for the page descriptor and waits for it. It then checks the descriptor's validity code, its supervisor-only and write-protect flags, and returns one of the following:

- the physical address, cache mode and updated descriptor (used bit set, modified bit set on writes), with a write-back strobe; or
- a fault with a cause code and no write-back.

Exactly one response follows every accepted request. A new request can be accepted in the same cycle that a response is presented.

Top module: `mmu_xlate_check`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o, walk_req_o and wb_valid_o are 0.
- R2: With translation control bit 15 clear, rsp_valid_o is 1 in the cycle after acceptance. In that cycle paddr_o equals the logical address, cmode_o is 00, there is no fault, no walk request and no write-back.
- R3: A window register hits when its bit 15 is set and the address bits 31:24 equal its bits 31:24 in every position where its bits 23:16 are 0 (a mask 1 means don't care). With translation on, a hit answers in the cycle after acceptance: paddr_o equals the logical address and cmode_o comes from the window's bits 6:5. A hit never faults, never walks and never writes back.
- R4: When both window registers hit, the cache mode comes from window register 0.
- R5: With translation on and no window hit, walk_req_o rises in the cycle after acceptance with walk_addr_o equal to the logical address. It stays high with a stable address until desc_valid_i is sampled, and rsp_valid_o follows in the next cycle. req_ready_o is 0 while walk_req_o is 1.
- R6: For a successful descriptor access, paddr_o is descriptor bits 31:12 joined with address bits 11:0 when control bit 14 is 0. When control bit 14 is 1, it is descriptor bits 31:13 joined with address bits 12:0.
- R7: Descriptor bits 1:0 give the type: 01 is a page. Type 00 faults with code 1, and types 10 and 11 fault with code 2. fault_o is 1 exactly when fault_code_o is nonzero; code 0 means success.
- R8: Descriptor bit 7 marks a supervisor-only page; an access with super_i low faults with code 3.
- R9: Descriptor bit 2 write-protects the page; a write access faults with code 4.
- R10: When several checks fail, the lowest-numbered cause wins: the type fault, then the supervisor fault, then the write-protect fault.
- R11: On success, wb_valid_o pulses with rsp_valid_o and cmode_o is descriptor bits 6:5. wb_desc_o is the descriptor with bit 3 set, and bit 4 is also set for a write. On a fault, wb_valid_o stays 0 and paddr_o and cmode_o are 0.
- R12: An instruction access (instr_i high) is treated as a read whatever write_i says: it is never write-protect faulted and never sets bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Unit idle, request accepted this cycle |
| laddr_i | input | 32 | Logical address |
| write_i | input | 1 | Write access |
| super_i | input | 1 | Supervisor mode access |
| instr_i | input | 1 | Instruction fetch access |
| tc_i | input | 16 | Translation control: bit 15 enable, bit 14 page size |
| tt0_i | input | 32 | Transparent window register 0 |
| tt1_i | input | 32 | Transparent window register 1 |
| walk_req_o | output | 1 | Descriptor wanted |
| walk_addr_o | output | 32 | Logical address to look up |
| desc_valid_i | input | 1 | Descriptor presented |
| desc_i | input | 32 | Page descriptor |
| rsp_valid_o | output | 1 | Result valid, one cycle |
| paddr_o | output | 32 | Physical address |
| cmode_o | output | 2 | Cache mode |
| fault_o | output | 1 | Access faulted |
| fault_code_o | output | 3 | Fault cause |
| wb_valid_o | output | 1 | Descriptor write-back strobe |
| wb_desc_o | output | 32 | Updated descriptor |

## Verification
The bench uses the default 12-bit small page and the fixed pair of window registers. With these settings every combination of the following can be enumerated in 1024 walked requests, each with a varied descriptor wait:

- the four type codes;
- the write-protect and supervisor page flags;
- all four cache modes;
- write, supervisor and instruction attributes;
- both page sizes.

Two window setups are then swept over all 256 upper address bytes. One setup contains overlap, exact-match and miss regions; the other has window 0 disabled and a full-range window 1. Together they exercise hit, miss, priority and fallback to the walk.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;

  localparam int unsigned TT_COUNT   = 2;
  localparam int unsigned TC_EN_BIT  = 15;
  localparam int unsigned TC_PS_BIT  = 14;
  localparam int unsigned TT_EN_BIT  = 15;
  localparam int unsigned D_WP_BIT   = 2;
  localparam int unsigned D_USED_BIT = 3;
  localparam int unsigned D_MOD_BIT  = 4;
  localparam int unsigned D_SUP_BIT  = 7;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_INVALID   = 3'd1,
    FLT_MALFORMED = 3'd2,
    FLT_SUPER     = 3'd3,
    FLT_WPROT     = 3'd4
  } fault_e;

  typedef enum logic {ST_IDLE, ST_WALK} state_e;

  typedef struct packed {
    logic [31:0] paddr;
    logic [1:0]  cmode;
    fault_e      fault;
    logic        wb;
    logic [31:0] wb_desc;
  } xlate_res_t;

endpackage

// File: rtl/mmu_tt_match.sv
module mmu_tt_match
  import mmu_xlate_pkg::*;
(
  input  logic [7:0]  addr_hi_i,
  input  logic [31:0] tt_i,
  output logic        hit_o,
  output logic [1:0]  cmode_o
);
  logic [7:0] base, ign;
  logic       unused_tt;

  assign base      = tt_i[31:24];
  assign ign       = tt_i[23:16];
  assign hit_o     = tt_i[TT_EN_BIT] && (((addr_hi_i ^ base) & ~ign) == 8'h00);
  assign cmode_o   = tt_i[6:5];
  assign unused_tt = ^{tt_i[14:7], tt_i[4:0]};
endmodule

// File: rtl/mmu_desc_eval.sv
module mmu_desc_eval
  import mmu_xlate_pkg::*;
#(
  parameter int unsigned SMALL_PAGE_BITS = 12
) (
  input  logic [31:0] laddr_i,
  input  logic        write_i,
  input  logic        super_i,
  input  logic        large_i,
  input  logic [31:0] desc_i,
  output xlate_res_t  res_o
);
  localparam logic [31:0] MASK_S = (32'h1 << SMALL_PAGE_BITS) - 32'h1;
  localparam logic [31:0] MASK_L = (32'h1 << (SMALL_PAGE_BITS + 1)) - 32'h1;

  logic [31:0] off_mask;
  fault_e      flt;

  assign off_mask = large_i ? MASK_L : MASK_S;

  // checks in priority order: type, supervisor, write-protect
  always_comb begin
    unique case (desc_i[1:0])
      2'b00:   flt = FLT_INVALID;
      2'b01:   flt = FLT_NONE;
      default: flt = FLT_MALFORMED;
    endcase
    if (flt == FLT_NONE) begin
      if (desc_i[D_SUP_BIT] && !super_i)      flt = FLT_SUPER;
      else if (desc_i[D_WP_BIT] && write_i)   flt = FLT_WPROT;
    end
  end

  always_comb begin
    res_o         = '0;
    res_o.fault   = flt;
    res_o.wb_desc = desc_i;
    if (flt == FLT_NONE) begin
      res_o.paddr                = (desc_i & ~off_mask) | (laddr_i & off_mask);
      res_o.cmode                = desc_i[6:5];
      res_o.wb                   = 1'b1;
      res_o.wb_desc[D_USED_BIT]  = 1'b1;
      res_o.wb_desc[D_MOD_BIT]   = desc_i[D_MOD_BIT] | write_i;
    end
  end
endmodule

// File: rtl/mmu_xlate_check.sv
module mmu_xlate_check
  import mmu_xlate_pkg::*;
#(
  parameter int unsigned SMALL_PAGE_BITS = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] laddr_i,
  input  logic        write_i,
  input  logic        super_i,
  input  logic        instr_i,
  input  logic [15:0] tc_i,
  input  logic [31:0] tt0_i,
  input  logic [31:0] tt1_i,
  output logic        walk_req_o,
  output logic [31:0] walk_addr_o,
  input  logic        desc_valid_i,
  input  logic [31:0] desc_i,
  output logic        rsp_valid_o,
  output logic [31:0] paddr_o,
  output logic [1:0]  cmode_o,
  output logic        fault_o,
  output logic [2:0]  fault_code_o,
  output logic        wb_valid_o,
  output logic [31:0] wb_desc_o
);
  state_e      state_q;
  logic [31:0] la_q;
  logic        wr_q, sup_q, large_q;
  logic        rsp_q;
  xlate_res_t  res_q, desc_res, pass_res;

  logic [TT_COUNT-1:0][31:0] tt_regs;
  logic [TT_COUNT-1:0]       tt_hit;
  logic [TT_COUNT-1:0][1:0]  tt_cm;
  logic                      tt_any;
  logic [1:0]                tt_sel_cm;
  logic                      accept, xl_en;
  logic                      unused_tc;

  assign tt_regs[0] = tt0_i;
  assign tt_regs[1] = tt1_i;
  assign unused_tc  = ^tc_i[13:0] ^ tc_i[TC_PS_BIT];

  for (genvar g = 0; g < TT_COUNT; g++) begin : g_tt
    mmu_tt_match u_tt (
      .addr_hi_i (laddr_i[31:24]),
      .tt_i      (tt_regs[g]),
      .hit_o     (tt_hit[g]),
      .cmode_o   (tt_cm[g])
    );
  end

  // lowest index wins
  always_comb begin
    tt_any    = 1'b0;
    tt_sel_cm = 2'b00;
    for (int k = TT_COUNT - 1; k >= 0; k--) begin
      if (tt_hit[k]) begin
        tt_any    = 1'b1;
        tt_sel_cm = tt_cm[k];
      end
    end
  end

  assign xl_en  = tc_i[TC_EN_BIT];
  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_comb begin
    pass_res       = '0;
    pass_res.paddr = laddr_i;
    pass_res.cmode = xl_en ? tt_sel_cm : 2'b00;
    pass_res.fault = FLT_NONE;
  end

  mmu_desc_eval #(.SMALL_PAGE_BITS(SMALL_PAGE_BITS)) u_eval (
    .laddr_i (la_q),
    .write_i (wr_q),
    .super_i (sup_q),
    .large_i (large_q),
    .desc_i  (desc_i),
    .res_o   (desc_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      la_q    <= '0;
      wr_q    <= 1'b0;
      sup_q   <= 1'b0;
      large_q <= 1'b0;
      rsp_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            la_q    <= laddr_i;
            wr_q    <= write_i && !instr_i;
            sup_q   <= super_i;
            large_q <= tc_i[TC_PS_BIT];
            if (!xl_en || tt_any) begin
              rsp_q <= 1'b1;
              res_q <= pass_res;
            end else begin
              state_q <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (desc_valid_i) begin
            rsp_q   <= 1'b1;
            res_q   <= desc_res;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign walk_req_o   = (state_q == ST_WALK);
  assign walk_addr_o  = la_q;
  assign rsp_valid_o  = rsp_q;
  assign paddr_o      = res_q.paddr;
  assign cmode_o      = res_q.cmode;
  assign fault_code_o = res_q.fault;
  assign fault_o      = (res_q.fault != FLT_NONE);
  assign wb_valid_o   = rsp_q && res_q.wb;
  assign wb_desc_o    = res_q.wb_desc;
endmodule

// File: rtl/mmu_xlate_check_sva.sv
module mmu_xlate_check_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] laddr_i,
  input logic [15:0] tc_i,
  input logic        walk_req_o,
  input logic [31:0] walk_addr_o,
  input logic        desc_valid_i,
  input logic        rsp_valid_o,
  input logic [31:0] paddr_o,
  input logic [1:0]  cmode_o,
  input logic        fault_o,
  input logic        wb_valid_o,
  input logic [31:0] wb_desc_o
);
  a_r2_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !tc_i[15]) |=>
      (rsp_valid_o && paddr_o == $past(laddr_i) && !fault_o && cmode_o == 2'b00));

  a_r5_walk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && !desc_valid_i) |=> (walk_req_o && $stable(walk_addr_o)));

  a_r5_resp_after_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && desc_valid_i) |=> (rsp_valid_o && !walk_req_o));

  a_r5_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(walk_req_o && req_ready_o));

  a_r11_wb_on_success: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (rsp_valid_o && !fault_o && wb_desc_o[3]));

  a_r11_fault_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fault_o) |-> (!wb_valid_o && paddr_o == 32'h0 && cmode_o == 2'b00));
endmodule

bind mmu_xlate_check mmu_xlate_check_sva u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .laddr_i      (laddr_i),
  .tc_i         (tc_i),
  .walk_req_o   (walk_req_o),
  .walk_addr_o  (walk_addr_o),
  .desc_valid_i (desc_valid_i),
  .rsp_valid_o  (rsp_valid_o),
  .paddr_o      (paddr_o),
  .cmode_o      (cmode_o),
  .fault_o      (fault_o),
  .wb_valid_o   (wb_valid_o),
  .wb_desc_o    (wb_desc_o)
);

// File: tb/tb_mmu_xlate_check.sv
module tb_mmu_xlate_check;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] laddr_i = '0;
  logic        write_i = 1'b0, super_i = 1'b0, instr_i = 1'b0;
  logic [15:0] tc_i = '0;
  logic [31:0] tt0_i = '0, tt1_i = '0;
  logic        walk_req_o;
  logic [31:0] walk_addr_o;
  logic        desc_valid_i = 1'b0;
  logic [31:0] desc_i = '0;
  logic        rsp_valid_o;
  logic [31:0] paddr_o;
  logic [1:0]  cmode_o;
  logic        fault_o;
  logic [2:0]  fault_code_o;
  logic        wb_valid_o;
  logic [31:0] wb_desc_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mmu_xlate_check dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit win_hit(input logic [31:0] tt, input logic [7:0] hi);
    if (!tt[15]) return 1'b0;
    for (int b = 0; b < 8; b++)
      if (!tt[16 + b] && (hi[b] != tt[24 + b])) return 1'b0;
    return 1'b1;
  endfunction

  // returns code; other values via outputs
  task automatic xact(input logic [31:0] la, input bit wr, input bit sup, input bit ins,
                      input logic [15:0] tc, input logic [31:0] t0, input logic [31:0] t1,
                      input logic [31:0] d, input int dly, output logic [2:0] got_code);
    bit          e_walk, is_wr;
    logic [31:0] e_pa, e_wd;
    logic [1:0]  e_cm;
    logic [2:0]  e_code;
    bit          e_wb;
    int          pb;
    string       ptag, ctag;
    is_wr = wr && !ins;
    e_walk = 0; e_pa = la; e_cm = 2'b00; e_code = 0; e_wb = 0; e_wd = d;
    ptag = "R2"; ctag = "R7";
    if (tc[15]) begin
      ptag = "R3";
      if (win_hit(t0, la[31:24]))      e_cm = t0[6:5];
      else if (win_hit(t1, la[31:24])) e_cm = t1[6:5];
      else begin
        e_walk = 1; ptag = "R6";
        if (d[1:0] == 2'b00)               e_code = 1;
        else if (d[1])                     e_code = 2;
        else if (d[7] && !sup)             begin e_code = 3; ctag = "R8"; end
        else if (is_wr && d[2])            begin e_code = 4; ctag = "R9"; end
        pb = tc[14] ? 13 : 12;
        if (e_code == 0) begin
          e_pa = ((d >> pb) << pb) | (la & ((32'h1 << pb) - 1));
          e_cm = d[6:5];
          e_wb = 1;
          e_wd = d | 32'h8 | (is_wr ? 32'h10 : 32'h0);
        end else begin
          e_pa = 0; e_cm = 0;
        end
      end
    end
    @(negedge clk_i);
    chk("R5", {31'b0, req_ready_o}, 32'd1);
    req_valid_i = 1; laddr_i = la; write_i = wr; super_i = sup; instr_i = ins;
    tc_i = tc; tt0_i = t0; tt1_i = t1;
    @(negedge clk_i);
    req_valid_i = 0;
    chk("R5", {31'b0, walk_req_o}, {31'b0, e_walk});
    if (e_walk && walk_req_o) begin
      chk("R5", walk_addr_o, la);
      chk("R5", {31'b0, rsp_valid_o}, 32'd0);
      for (int w = 0; w < dly; w++) begin
        @(negedge clk_i);
        chk("R5", {31'b0, walk_req_o}, 32'd1);
      end
      desc_valid_i = 1; desc_i = d;
      @(negedge clk_i);
      desc_valid_i = 0;
    end
    chk(ptag, {31'b0, rsp_valid_o}, 32'd1);
    chk(ptag, paddr_o, e_pa);
    chk(e_walk ? "R11" : ptag, {30'b0, cmode_o}, {30'b0, e_cm});
    chk(ctag, {29'b0, fault_code_o}, {29'b0, e_code});
    chk("R7", {31'b0, fault_o}, {31'b0, (e_code != 0)});
    chk("R11", {31'b0, wb_valid_o}, {31'b0, e_wb});
    if (e_wb) chk("R11", wb_desc_o, e_wd);
    got_code = fault_code_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] c;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {31'b0, req_ready_o}, 32'd1);
    chk("R1", {31'b0, rsp_valid_o}, 32'd0);
    chk("R1", {31'b0, walk_req_o}, 32'd0);
    chk("R1", {31'b0, wb_valid_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", {31'b0, req_ready_o}, 32'd1);

    // R2 translation disabled
    for (int i = 0; i < 16; i++)
      xact(32'h9E37_79B1 * (i + 1), i[0], i[1], 1'b0, 16'h4000 * i[2], 32'h00FF_E040, 32'h0,
           32'h0, 0, c);

    // descriptor space sweep: R6 R7 R8 R9 R11 R12
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] d, la;
      d  = ((32'h6F4A_1235 * (i + 7)) & 32'hFFFF_FF18)
         | {24'b0, i[3], i[5:4], 2'b00, i[2], i[1:0]};
      la = 32'hA5C3_0000 ^ (32'h0001_1357 * i);
      xact(la, i[6], i[7], i[8], {1'b1, i[9], 14'h0}, 32'h0, 32'h0, d, i % 3, c);
    end

    // window sweep A: overlap, single, miss (R3 R4)
    for (int h = 0; h < 256; h++)
      xact({h[7:0], 24'h35_7A9C}, h[0], 1'b0, 1'b0, 16'h8000, 32'h3C0F_8020, 32'h3000_8060,
           32'h1234_5001 | {27'b0, h[1], 4'b0}, 1, c);
    // window sweep B: window 0 disabled, full range window 1
    for (int h = 0; h < 256; h++)
      xact({h[7:0], 24'h01_0203}, 1'b1, 1'b0, 1'b0, 16'hC000, 32'h3C0F_0020, 32'h00FF_E040,
           32'h0, 0, c);

    // R4 both windows match, window 0 wins
    xact(32'h3012_3456, 1'b0, 1'b0, 1'b0, 16'h8000, 32'h3C0F_8020, 32'h3000_8060, 32'h0, 0, c);
    chk("R4", {30'b0, cmode_o}, 32'd1);

    // R10 priority
    xact(32'h4000_1000, 1'b1, 1'b0, 1'b0, 16'h8000, 32'h0, 32'h0, 32'h0000_0084, 0, c);
    chk("R10", {29'b0, c}, 32'd1);
    xact(32'h4000_1000, 1'b1, 1'b0, 1'b0, 16'h8000, 32'h0, 32'h0, 32'h0000_0086, 0, c);
    chk("R10", {29'b0, c}, 32'd2);
    xact(32'h4000_1000, 1'b1, 1'b0, 1'b0, 16'h8000, 32'h0, 32'h0, 32'h0000_0085, 0, c);
    chk("R10", {29'b0, c}, 32'd3);

    // R12 instruction write to protected page
    xact(32'h4000_1ABC, 1'b1, 1'b1, 1'b1, 16'h8000, 32'h0, 32'h0, 32'h7777_7005, 2, c);
    chk("R12", {29'b0, c}, 32'd0);
    chk("R12", {31'b0, wb_desc_o[4]}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule